// File: doc/BRIEF.md
# NAND Page Access Sequencer

This block is a host-side sequencer for a small-page NAND flash with an 8-bit multiplexed command/address/data bus. A client hands it one request at a time over a valid/ready port. The request is a page read, a page program or a block erase, and it carries a row (page) address, a column offset and a byte count. The sequencer then produces the command-latch, address-latch, chip-enable, write-strobe and read-strobe signals and the bus bytes. It waits on the ready/busy line and moves payload through a byte stream in each direction.

A page is 528 bytes: 512 main bytes followed by 16 spare bytes. An erase block is 32 consecutive pages. The column offset selects which pointer opcode opens the access. Reads stream any run of bytes starting at the column. Programs load anywhere from 1 to 528 bytes before the confirm opcode. After every program or erase, the sequencer reads the flash status byte and reports bit 0 as the fail flag. Every strobe width, setup and hold interval is a clock-count parameter, so the block can be retimed for any clock rate.

Top module: `nand_seq`

## Requirements
- R1: Out of reset and whenever no request is in progress, `req_ready` is 1, chip enable is high (inactive), both strobes are high, CLE and ALE are 0 and the bus is not driven. `req_ready` is 0 from the cycle after acceptance until the request completes.
- R2: Each read and each program starts with a pointer command chosen from the column: 00h for columns 0-255, 01h for 256-511, 50h for 512-527.
- R3: The address bytes follow the command with ALE high. For read and program, the first byte is column bits [7:0] and then come ADDR_CYC-1 row bytes, least significant first (ADDR_CYC bytes in all). For erase, only the ADDR_CYC-1 row bytes are sent.
- R4: Every write cycle holds the write strobe low for exactly T_WP clocks, and the strobe has been high for at least T_SU clocks before it falls. CLE, ALE and the driven byte do not change while the strobe is low.
- R5: Every read strobe is low for exactly T_RP clocks and high for at least T_REH clocks before the next fall. The bus is never driven while the read strobe is low. The two strobes are never low together.
- R6: After the last address byte of a read, or after a confirm opcode, the sequencer waits T_WB clocks. It then holds off every read strobe until ready/busy is high.
- R7: A read delivers exactly `req_len` bytes on `rd_data` with a one-cycle `rd_valid`, in column order starting at the requested column. A read ends with `done` and `fail`=0.
- R8: A program sends its pointer command, then 80h, then the address, then exactly `req_len` (1 to 528) bytes taken from the write stream one per `wr_valid`/`wr_ready` handshake, then 10h.
- R9: An erase sends 60h, then the row bytes, then D0h.
- R10: After 10h or D0h and the ready wait, the sequencer sends 70h, performs one read cycle, and pulses `done` for one cycle with `fail` equal to bit 0 of the byte it read.
- R11: CLE and ALE are never high together, and chip enable stays low for the whole of a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and accepting |
| req_op | input | 2 | 0 read, 1 program, 2 erase, 3 treated as read |
| req_row | input | ROW_W | Page address (row) |
| req_col | input | 10 | Column offset 0-527 |
| req_len | input | 10 | Byte count 1-528 (read/program) |
| wr_data | input | 8 | Program payload byte |
| wr_valid | input | 1 | Payload byte available |
| wr_ready | output | 1 | Payload byte taken this cycle |
| rd_data | output | 8 | Read payload byte |
| rd_valid | output | 1 | Read byte valid, one cycle |
| done | output | 1 | Request finished, one cycle |
| fail | output | 1 | Status bit 0 of last program/erase; 0 after a read |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_io_out | output | 8 | Bus byte driven to flash |
| nf_io_oe | output | 1 | Bus drive enable |
| nf_io_in | input | 8 | Bus byte from flash |
| nf_rb | input | 1 | Ready (1) / busy (0) |

## Verification
The bound checker watches the pin-level rules on every cycle: CLE and ALE are exclusive, the two strobes never overlap, the bus drive follows the write strobe and stays off under the read strobe, no read strobe falls while the flash is busy, and the latch controls hold still under the write strobe. It also checks that chip enable and `req_ready` agree with idleness. Other behaviours need the bench's scenarios and its behavioural flash: the opcode choice for each column region, the count and order of address bytes, exact strobe widths, payload landing in the right page and column, the ordering of partial and full-page programs, erase clearing the whole block, and the fail flag following the status byte.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  localparam int COL_W      = 10;
  localparam int PAGE_BYTES = 528;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2
  } op_e;

  typedef enum logic {
    CYC_WR = 1'b0,
    CYC_RD = 1'b1
  } cyc_e;

  localparam logic [7:0] OPC_PTR_LO  = 8'h00;
  localparam logic [7:0] OPC_PTR_HI  = 8'h01;
  localparam logic [7:0] OPC_PTR_SP  = 8'h50;
  localparam logic [7:0] OPC_PROG    = 8'h80;
  localparam logic [7:0] OPC_PCONF   = 8'h10;
  localparam logic [7:0] OPC_ERASE   = 8'h60;
  localparam logic [7:0] OPC_ECONF   = 8'hD0;
  localparam logic [7:0] OPC_STATUS  = 8'h70;
endpackage

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen
  import nand_seq_pkg::*;
#(
  parameter int T_SU  = 3,
  parameter int T_WP  = 4,
  parameter int T_WH  = 3,
  parameter int T_RP  = 7,
  parameter int T_REH = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  cyc_e       kind,
  input  logic       cle_i,
  input  logic       ale_i,
  input  logic [7:0] dat_i,
  input  logic [7:0] io_in,
  output logic       busy,
  output logic       done,
  output logic       cle_o,
  output logic       ale_o,
  output logic       we_n,
  output logic       re_n,
  output logic [7:0] io_out,
  output logic       io_oe,
  output logic [7:0] rd_byte
);
  localparam int CW = 8;

  typedef enum logic [2:0] {
    PH_IDLE, PH_WSU, PH_WLO, PH_WHO, PH_RLO, PH_RHI
  } phase_e;

  phase_e          phase_q, phase_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            cle_q, cle_d, ale_q, ale_d;
  logic [7:0]      dat_q, dat_d, rd_q, rd_d;
  logic [CW-1:0]   ph_len;
  logic            last;

  always_comb begin
    case (phase_q)
      PH_WSU:  ph_len = CW'(T_SU);
      PH_WLO:  ph_len = CW'(T_WP);
      PH_WHO:  ph_len = CW'(T_WH);
      PH_RLO:  ph_len = CW'(T_RP);
      PH_RHI:  ph_len = CW'(T_REH);
      default: ph_len = CW'(1);
    endcase
  end

  assign busy = (phase_q != PH_IDLE);
  assign last = busy && (cnt_q == ph_len - CW'(1));
  assign done = last && ((phase_q == PH_WHO) || (phase_q == PH_RHI));

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    cle_d   = cle_q;
    ale_d   = ale_q;
    dat_d   = dat_q;
    rd_d    = rd_q;
    if (!busy) begin
      if (start) begin
        phase_d = (kind == CYC_WR) ? PH_WSU : PH_RLO;
        cnt_d   = '0;
        cle_d   = cle_i;
        ale_d   = ale_i;
        dat_d   = dat_i;
      end
    end else if (last) begin
      cnt_d = '0;
      case (phase_q)
        PH_WSU:  phase_d = PH_WLO;
        PH_WLO:  phase_d = PH_WHO;
        PH_RLO:  begin phase_d = PH_RHI; rd_d = io_in; end
        default: phase_d = PH_IDLE;
      endcase
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      cle_q   <= 1'b0;
      ale_q   <= 1'b0;
      dat_q   <= '0;
      rd_q    <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      cle_q   <= cle_d;
      ale_q   <= ale_d;
      dat_q   <= dat_d;
      rd_q    <= rd_d;
    end
  end

  assign io_oe   = (phase_q == PH_WSU) || (phase_q == PH_WLO) || (phase_q == PH_WHO);
  assign we_n    = (phase_q != PH_WLO);
  assign re_n    = (phase_q != PH_RLO);
  assign cle_o   = cle_q && io_oe;
  assign ale_o   = ale_q && io_oe;
  assign io_out  = dat_q;
  assign rd_byte = rd_q;
endmodule

// File: rtl/nand_ptr_sel.sv
module nand_ptr_sel
  import nand_seq_pkg::*;
(
  input  logic [1:0] col_hi,
  output logic [7:0] opcode
);
  always_comb begin
    if (col_hi[1])      opcode = OPC_PTR_SP;
    else if (col_hi[0]) opcode = OPC_PTR_HI;
    else                opcode = OPC_PTR_LO;
  end
endmodule

// File: rtl/nand_addr_mux.sv
module nand_addr_mux #(
  parameter int ADDR_CYC = 3,
  parameter int IW       = 10,
  localparam int ROW_W   = 8 * (ADDR_CYC - 1)
) (
  input  logic [IW-1:0]    idx,
  input  logic             skip_col,
  input  logic [7:0]       col_lo,
  input  logic [ROW_W-1:0] row,
  output logic [7:0]       addr_byte
);
  logic [7:0] slot [ADDR_CYC];

  assign slot[0] = col_lo;
  for (genvar g = 1; g < ADDR_CYC; g++) begin : g_row
    assign slot[g] = row[8*(g-1) +: 8];
  end

  logic [IW:0] sel;
  assign sel = {1'b0, idx} + {{IW{1'b0}}, skip_col};

  always_comb begin
    addr_byte = 8'hFF;
    for (int k = 0; k < ADDR_CYC; k++) begin
      if (sel == (IW+1)'(k)) addr_byte = slot[k];
    end
  end
endmodule

// File: rtl/nand_seq.sv
module nand_seq
  import nand_seq_pkg::*;
#(
  parameter int ADDR_CYC = 3,
  parameter int T_SU     = 3,
  parameter int T_WP     = 4,
  parameter int T_WH     = 3,
  parameter int T_RP     = 7,
  parameter int T_REH    = 6,
  parameter int T_WB     = 25,
  localparam int ROW_W   = 8 * (ADDR_CYC - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [ROW_W-1:0] req_row,
  input  logic [9:0]       req_col,
  input  logic [9:0]       req_len,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             done,
  output logic             fail,
  output logic             nf_ce_n,
  output logic             nf_cle,
  output logic             nf_ale,
  output logic             nf_we_n,
  output logic             nf_re_n,
  output logic [7:0]       nf_io_out,
  output logic             nf_io_oe,
  input  logic [7:0]       nf_io_in,
  input  logic             nf_rb
);
  localparam int IW  = COL_W;
  localparam int WBW = $clog2(T_WB + 1);
  localparam logic [WBW-1:0] WB_LAST = WBW'(T_WB - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_PTR, S_SETUP, S_ADDR, S_WDATA, S_CONF,
    S_WB, S_RB, S_RDATA, S_STCMD, S_STRD
  } state_e;

  state_e           state_q, state_d;
  op_e              op_q, op_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic [9:0]       col_q, col_d;
  logic [9:0]       len_q, len_d;
  logic [IW-1:0]    idx_q, idx_d;
  logic [WBW-1:0]   wb_q, wb_d;
  logic             done_q, done_d, fail_q, fail_d;

  logic       gen_busy, gen_done, issue;
  cyc_e       gen_kind;
  logic       gen_cle, gen_ale;
  logic [7:0] gen_dat, gen_rd;
  logic [7:0] ptr_opc, addr_byte;
  logic [IW-1:0] addr_last;
  logic       is_read, is_prog;

  assign is_read   = (op_q == OP_READ);
  assign is_prog   = (op_q == OP_PROG);
  assign addr_last = (op_q == OP_ERASE) ? IW'(ADDR_CYC - 2) : IW'(ADDR_CYC - 1);

  nand_ptr_sel u_ptr (
    .col_hi (col_q[9:8]),
    .opcode (ptr_opc)
  );

  nand_addr_mux #(.ADDR_CYC(ADDR_CYC), .IW(IW)) u_addr (
    .idx       (idx_q),
    .skip_col  (op_q == OP_ERASE),
    .col_lo    (col_q[7:0]),
    .row       (row_q),
    .addr_byte (addr_byte)
  );

  // cycle issue and bus content per state
  always_comb begin
    issue    = 1'b0;
    gen_kind = CYC_WR;
    gen_cle  = 1'b0;
    gen_ale  = 1'b0;
    gen_dat  = 8'h00;
    case (state_q)
      S_PTR:   begin issue = 1'b1; gen_cle = 1'b1; gen_dat = ptr_opc; end
      S_SETUP: begin issue = 1'b1; gen_cle = 1'b1;
                     gen_dat = is_prog ? OPC_PROG : OPC_ERASE; end
      S_ADDR:  begin issue = 1'b1; gen_ale = 1'b1; gen_dat = addr_byte; end
      S_WDATA: begin issue = wr_valid; gen_dat = wr_data; end
      S_CONF:  begin issue = 1'b1; gen_cle = 1'b1;
                     gen_dat = is_prog ? OPC_PCONF : OPC_ECONF; end
      S_STCMD: begin issue = 1'b1; gen_cle = 1'b1; gen_dat = OPC_STATUS; end
      S_RDATA: begin issue = 1'b1; gen_kind = CYC_RD; end
      S_STRD:  begin issue = 1'b1; gen_kind = CYC_RD; end
      default: ;
    endcase
  end

  nand_strobe_gen #(
    .T_SU(T_SU), .T_WP(T_WP), .T_WH(T_WH), .T_RP(T_RP), .T_REH(T_REH)
  ) u_strobe (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (issue && !gen_busy),
    .kind    (gen_kind),
    .cle_i   (gen_cle),
    .ale_i   (gen_ale),
    .dat_i   (gen_dat),
    .io_in   (nf_io_in),
    .busy    (gen_busy),
    .done    (gen_done),
    .cle_o   (nf_cle),
    .ale_o   (nf_ale),
    .we_n    (nf_we_n),
    .re_n    (nf_re_n),
    .io_out  (nf_io_out),
    .io_oe   (nf_io_oe),
    .rd_byte (gen_rd)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    op_d    = op_q;
    row_d   = row_q;
    col_d   = col_q;
    len_d   = len_q;
    idx_d   = idx_q;
    wb_d    = wb_q;
    done_d  = 1'b0;
    fail_d  = fail_q;
    case (state_q)
      S_IDLE: if (req_valid) begin
        op_d    = (req_op == 2'd3) ? OP_READ : op_e'(req_op);
        row_d   = req_row;
        col_d   = req_col;
        len_d   = req_len;
        idx_d   = '0;
        state_d = (req_op == 2'd2) ? S_SETUP : S_PTR;
      end
      S_PTR:   if (gen_done) state_d = is_read ? S_ADDR : S_SETUP;
      S_SETUP: if (gen_done) state_d = S_ADDR;
      S_ADDR: if (gen_done) begin
        if (idx_q == addr_last) begin
          idx_d = '0;
          if (is_read)      state_d = S_WB;
          else if (is_prog) state_d = S_WDATA;
          else              state_d = S_CONF;
        end else begin
          idx_d = idx_q + IW'(1);
        end
      end
      S_WDATA: if (gen_done) begin
        if (idx_q == len_q - 10'd1) begin
          idx_d   = '0;
          state_d = S_CONF;
        end else begin
          idx_d = idx_q + IW'(1);
        end
      end
      S_CONF: if (gen_done) state_d = S_WB;
      S_WB: begin
        if (wb_q == WB_LAST) begin
          wb_d    = '0;
          state_d = S_RB;
        end else begin
          wb_d = wb_q + WBW'(1);
        end
      end
      S_RB: if (nf_rb) state_d = is_read ? S_RDATA : S_STCMD;
      S_RDATA: if (gen_done) begin
        if (idx_q == len_q - 10'd1) begin
          idx_d   = '0;
          done_d  = 1'b1;
          fail_d  = 1'b0;
          state_d = S_IDLE;
        end else begin
          idx_d = idx_q + IW'(1);
        end
      end
      S_STCMD: if (gen_done) state_d = S_STRD;
      S_STRD: if (gen_done) begin
        fail_d  = gen_rd[0];
        done_d  = 1'b1;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      op_q    <= OP_READ;
      row_q   <= '0;
      col_q   <= '0;
      len_q   <= '0;
      idx_q   <= '0;
      wb_q    <= '0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      row_q   <= row_d;
      col_q   <= col_d;
      len_q   <= len_d;
      idx_q   <= idx_d;
      wb_q    <= wb_d;
      done_q  <= done_d;
      fail_q  <= fail_d;
    end
  end

  assign req_ready = (state_q == S_IDLE);
  assign nf_ce_n   = (state_q == S_IDLE);
  assign wr_ready  = (state_q == S_WDATA) && !gen_busy;
  assign rd_valid  = (state_q == S_RDATA) && gen_done;
  assign rd_data   = gen_rd;
  assign done      = done_q;
  assign fail      = fail_q;
endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rd_valid,
  input logic done,
  input logic nf_ce_n,
  input logic nf_cle,
  input logic nf_ale,
  input logic nf_we_n,
  input logic nf_re_n,
  input logic nf_io_oe,
  input logic nf_rb
);
  // R1: idle implies the flash is deselected
  a_r1_idle_ce: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> nf_ce_n);

  // R11: latch controls exclusive
  a_r11_cle_ale: assert property (@(posedge clk) disable iff (!rst_n)
    !(nf_cle && nf_ale));

  // R11: chip enable held low while reads stream
  a_r11_ce_rd: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !nf_ce_n);

  // R5: strobes never overlap
  a_r5_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nf_we_n && !nf_re_n));

  // R4: bus driven under the write strobe
  a_r4_we_drives: assert property (@(posedge clk) disable iff (!rst_n)
    !nf_we_n |-> nf_io_oe);

  // R5: bus released under the read strobe
  a_r5_re_released: assert property (@(posedge clk) disable iff (!rst_n)
    !nf_re_n |-> !nf_io_oe);

  // R4: latch controls steady while write strobe low
  a_r4_we_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!nf_we_n && $past(!nf_we_n)) |-> ($stable(nf_cle) && $stable(nf_ale)));

  // R6: no read strobe while busy
  a_r6_re_needs_rb: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nf_re_n) |-> nf_rb);

  // R10: completion lands in idle
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);
endmodule

bind nand_seq nand_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rd_valid  (rd_valid),
  .done      (done),
  .nf_ce_n   (nf_ce_n),
  .nf_cle    (nf_cle),
  .nf_ale    (nf_ale),
  .nf_we_n   (nf_we_n),
  .nf_re_n   (nf_re_n),
  .nf_io_oe  (nf_io_oe),
  .nf_rb     (nf_rb)
);

// File: tb/nand_seq_test.sv
module nand_seq_test;
  localparam int ADDR_CYC = 3;
  localparam int T_SU = 3, T_WP = 4, T_WH = 3, T_RP = 7, T_REH = 6, T_WB = 25;
  localparam int BUSY_RD = 40, BUSY_PG = 60, BUSY_ER = 80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 1'b0, req_ready;
  logic [1:0]  req_op = 2'd0;
  logic [15:0] req_row = '0;
  logic [9:0]  req_col = '0, req_len = '0;
  logic [7:0]  wr_data = '0;
  logic        wr_valid = 1'b0, wr_ready;
  logic [7:0]  rd_data;
  logic        rd_valid, done, fail;
  logic        nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_io_oe;
  logic [7:0]  nf_io_out;
  logic [7:0]  nf_io_in = 8'hFF;
  logic        nf_rb = 1'b1;

  nand_seq #(.ADDR_CYC(ADDR_CYC), .T_SU(T_SU), .T_WP(T_WP), .T_WH(T_WH),
             .T_RP(T_RP), .T_REH(T_REH), .T_WB(T_WB)) uut (.*);

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural flash model ----------------
  logic [7:0] mem [int];
  typedef struct { int a; logic [7:0] d; } pend_t;
  pend_t pend[$];
  logic [7:0] cmd_log[$];
  int addr_log = 0;
  int m_mode = 0;   // 0 idle, 1 data out, 2 status, 3 addr collect
  int m_cmd = 0;    // 0 read, 1 prog, 2 erase
  int m_ptr = 0, m_acnt = 0, m_row = 0, m_pos = 0, m_bcnt = 0;
  bit m_fail = 0, inj_fail = 0;
  bit prev_we = 1, prev_re = 1;
  int we_lo = 0, we_hi = 1000, re_lo = 0, re_hi = 1000;
  int we_err = 0, re_err = 0, busy_err = 0, latch_err = 0;

  function automatic logic [7:0] rd_mem(int a);
    if (mem.exists(a)) return mem[a];
    return 8'hFF;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_bcnt = 0; prev_we = 1; prev_re = 1;
      we_lo = 0; we_hi = 1000; re_lo = 0; re_hi = 1000;
      nf_rb <= 1'b1; nf_io_in <= 8'hFF;
    end else begin
      if (m_bcnt > 0) m_bcnt--;
      if (nf_cle && nf_ale) latch_err++;
      // strobe timing monitor
      if (!nf_we_n) begin
        if (prev_we && we_hi < T_SU) we_err++;
        we_lo++; we_hi = 0;
      end else begin
        if (!prev_we && we_lo != T_WP) we_err++;
        we_lo = 0; we_hi++;
      end
      if (!nf_re_n) begin
        if (prev_re && re_hi < T_REH) re_err++;
        if (prev_re && (m_bcnt > 0 || !nf_rb)) busy_err++;
        re_lo++; re_hi = 0;
      end else begin
        if (!prev_re && re_lo != T_RP) re_err++;
        re_lo = 0; re_hi++;
      end
      // write cycle decode at strobe rise
      if (!prev_we && nf_we_n) begin
        if (nf_cle) begin
          cmd_log.push_back(nf_io_out);
          case (nf_io_out)
            8'h00: begin m_ptr = 0;   m_cmd = 0; m_mode = 3; m_acnt = 0; end
            8'h01: begin m_ptr = 256; m_cmd = 0; m_mode = 3; m_acnt = 0; end
            8'h50: begin m_ptr = 512; m_cmd = 0; m_mode = 3; m_acnt = 0; end
            8'h80: begin m_cmd = 1; m_mode = 3; m_acnt = 0; pend.delete(); end
            8'h60: begin m_cmd = 2; m_mode = 3; m_acnt = 0; end
            8'h10: begin
              foreach (pend[i]) mem[pend[i].a] = rd_mem(pend[i].a) & pend[i].d;
              pend.delete(); m_fail = inj_fail; m_bcnt = BUSY_PG; m_mode = 0; m_ptr = 0;
            end
            8'hD0: begin
              for (int p = 0; p < 32; p++)
                for (int c = 0; c < 528; c++)
                  if (mem.exists(((m_row & ~31) + p) * 528 + c))
                    mem.delete(((m_row & ~31) + p) * 528 + c);
              m_fail = inj_fail; m_bcnt = BUSY_ER; m_mode = 0; m_ptr = 0;
            end
            8'h70: m_mode = 2;
            default: m_mode = 0;
          endcase
        end else if (nf_ale) begin
          addr_log++;
          if (m_cmd == 2) begin
            if (m_acnt == 0) m_row = 0;
            m_row = m_row | (int'(nf_io_out) << (8 * m_acnt));
          end else begin
            if (m_acnt == 0) begin
              m_row = 0;
              m_pos = (m_ptr == 512) ? 512 + (nf_io_out & 8'h0F) : m_ptr + nf_io_out;
            end else begin
              m_row = m_row | (int'(nf_io_out) << (8 * (m_acnt - 1)));
            end
            if (m_cmd == 0 && m_acnt == ADDR_CYC - 1) begin
              m_bcnt = BUSY_RD; m_mode = 1;
            end
          end
          m_acnt++;
        end else if (m_cmd == 1) begin
          pend.push_back('{a: m_row * 528 + m_pos, d: nf_io_out});
          m_pos++;
        end
      end
      if (!prev_re && nf_re_n && m_mode == 1) m_pos++;
      prev_we = nf_we_n;
      prev_re = nf_re_n;
      nf_rb <= (m_bcnt == 0);
      nf_io_in <= (m_mode == 2) ? (8'hC0 | {7'd0, m_fail}) : rd_mem(m_row * 528 + m_pos);
    end
  end

  // ---------------- stream drivers ----------------
  logic [7:0] wq[$];
  logic [7:0] rq[$];
  always @(negedge clk) begin
    wr_valid <= (wq.size() > 0);
    wr_data  <= (wq.size() > 0) ? wq[0] : 8'h00;
  end
  always @(posedge clk) begin
    if (wr_valid && wr_ready) void'(wq.pop_front());
    if (rd_valid) rq.push_back(rd_data);
  end

  bit last_fail;
  int busy_seen;

  task automatic run_op(input int op, input int row, input int col, input int len);
    cmd_log.delete(); addr_log = 0; rq.delete();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op[1:0]; req_row = row[15:0];
    req_col = col[9:0]; req_len = len[9:0];
    @(negedge clk);
    req_valid = 1'b0;
    busy_seen = req_ready ? 0 : 1;
    while (!done) @(negedge clk);
    last_fail = fail;
    @(negedge clk);
  endtask

  task automatic check_log(input string tag, input logic [7:0] e0, input logic [7:0] e1,
                           input logic [7:0] e2, input logic [7:0] e3, input int n);
    logic [7:0] ex[4];
    bit ok;
    ex[0] = e0; ex[1] = e1; ex[2] = e2; ex[3] = e3;
    ok = (cmd_log.size() == n);
    for (int i = 0; i < n && ok; i++) if (cmd_log[i] != ex[i]) ok = 0;
    chk(ok, tag, (cmd_log.size() > 0) ? {cmd_log.size(), cmd_log[0]} : 0, {n, e0});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int mism;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(req_ready == 1, "R1 req_ready", req_ready, 1);
    chk({nf_ce_n, nf_we_n, nf_re_n} == 3'b111, "R1 strobes idle", {nf_ce_n, nf_we_n, nf_re_n}, 7);
    chk({nf_cle, nf_ale, nf_io_oe, done} == 4'b0, "R1 controls idle", {nf_cle, nf_ale, nf_io_oe, done}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8 partial program, first half, pointer 00h
    wq = '{8'hA1, 8'hA2, 8'hA3, 8'hA4};
    run_op(1, 5, 10, 4);
    chk(busy_seen == 1, "R1 ready drops while busy", busy_seen, 1);
    check_log("R8 R2 R10 prog cmds 00 80 10 70", 8'h00, 8'h80, 8'h10, 8'h70, 4);
    chk(addr_log == ADDR_CYC, "R3 prog addr count", addr_log, ADDR_CYC);
    chk(last_fail == 0, "R10 prog pass", last_fail, 0);
    chk(wq.size() == 0, "R8 payload consumed", wq.size(), 0);

    // R7 read spanning unwritten edges
    run_op(0, 5, 9, 6);
    check_log("R2 read ptr 00", 8'h00, 0, 0, 0, 1);
    chk(addr_log == ADDR_CYC, "R3 read addr count", addr_log, ADDR_CYC);
    chk(rq.size() == 6, "R7 read count", rq.size(), 6);
    if (rq.size() == 6)
      chk({rq[0], rq[1], rq[2], rq[3], rq[4], rq[5]} == 48'hFFA1A2A3A4FF, "R7 read data",
          rq[1], 8'hA1);
    chk(last_fail == 0, "R7 read fail clear", last_fail, 0);

    // R2 second half pointer
    wq = '{8'h11, 8'h22, 8'h33};
    run_op(1, 6, 300, 3);
    check_log("R2 prog ptr 01", 8'h01, 8'h80, 8'h10, 8'h70, 4);
    run_op(0, 6, 300, 3);
    check_log("R2 read ptr 01", 8'h01, 0, 0, 0, 1);
    chk(rq.size() == 3 && rq[0] == 8'h11 && rq[2] == 8'h33, "R7 second half data",
        (rq.size() > 0) ? rq[0] : 0, 8'h11);

    // R2 spare area pointer
    wq = '{8'h5A, 8'hA5};
    run_op(1, 6, 515, 2);
    check_log("R2 prog ptr 50", 8'h50, 8'h80, 8'h10, 8'h70, 4);
    run_op(0, 6, 515, 2);
    check_log("R2 read ptr 50", 8'h50, 0, 0, 0, 1);
    chk(rq.size() == 2 && rq[0] == 8'h5A && rq[1] == 8'hA5, "R7 spare data",
        (rq.size() > 0) ? rq[0] : 0, 8'h5A);

    // R8 full page program and readback
    for (int i = 0; i < 528; i++) wq.push_back(8'(i ^ (i >> 3)));
    run_op(1, 7, 0, 528);
    chk(wq.size() == 0, "R8 full page consumed", wq.size(), 0);
    run_op(0, 7, 0, 528);
    mism = 0;
    for (int i = 0; i < 528; i++) if (i >= rq.size() || rq[i] != 8'(i ^ (i >> 3))) mism++;
    chk(mism == 0, "R7 R8 full page match", mism, 0);

    // R10 fail flag from status
    inj_fail = 1;
    wq = '{8'h00};
    run_op(1, 40, 0, 1);
    chk(last_fail == 1, "R10 prog fail reported", last_fail, 1);
    inj_fail = 0;

    // R9 erase block holding pages 0..31
    run_op(2, 5, 0, 1);
    check_log("R9 erase cmds 60 D0 70", 8'h60, 8'hD0, 8'h70, 0, 3);
    chk(addr_log == ADDR_CYC - 1, "R3 erase addr count", addr_log, ADDR_CYC - 1);
    chk(last_fail == 0, "R10 erase pass", last_fail, 0);
    run_op(0, 7, 0, 2);
    chk(rq.size() == 2 && rq[0] == 8'hFF && rq[1] == 8'hFF, "R9 block erased",
        (rq.size() > 0) ? rq[0] : 0, 8'hFF);
    run_op(0, 40, 0, 1);
    chk(rq.size() == 1 && rq[0] == 8'h00, "R9 other block kept",
        (rq.size() > 0) ? rq[0] : 0, 8'h00);
    inj_fail = 1;
    run_op(2, 64, 0, 1);
    chk(last_fail == 1, "R10 erase fail reported", last_fail, 1);
    inj_fail = 0;

    // timing and protocol counters
    chk(we_err == 0, "R4 write strobe timing", we_err, 0);
    chk(re_err == 0, "R5 read strobe timing", re_err, 0);
    chk(busy_err == 0, "R6 read strobe while busy", busy_err, 0);
    chk(latch_err == 0, "R11 cle ale overlap", latch_err, 0);
    chk(req_ready == 1 && nf_ce_n == 1, "R1 R11 idle after ops", {req_ready, nf_ce_n}, 3);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule